// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each data beat of one memory burst. A one-cycle start pulse captures a starting column, a length selection (4 or 8 beats) and an ordering selection (sequential-in-nibble or interleaved). From the next cycle the block shows one address per clock. A valid flag marks each beat, and a last flag marks the final one. Address bits above the burst boundary are carried through unchanged.

The ordering is not a plain binary count. In sequential mode the two lowest bits count upward and wrap inside a group of four beats. For an 8-beat burst, bit 2 flips once the first group of four is complete. In interleaved mode the low bits are the start value XOR the beat number.

The block also checks command spacing. A start that lands inside a running burst is accepted only at two points: on the final beat, which gives a seamless follow-on burst, or at the half-way point of an 8-beat burst. Any other start is dropped, and an error pulse is raised.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, valid, last and error outputs are all low.
- R2: Sequential, length 4 (len8 = 0, interleave = 0): beat i carries low bits [1:0] = (start[1:0] + i) mod 4; bit 2 and every higher bit equal the start value.
- R3: Sequential, length 8 (len8 = 1, interleave = 0): beat i carries bits [1:0] = (start[1:0] + i) mod 4 and bit 2 = start[2] XOR (i >= 4). For example, start 5 gives 5,6,7,4,1,2,3,0.
- R4: Interleaved (interleave = 1), either length: bits [2:0] of beat i equal start[2:0] XOR i. For example, start 3 at length 8 gives 3,2,1,0,7,6,5,4.
- R5: Column bits at position 3 and above equal the captured start value on every beat.
- R6: A start accepted at a clock edge shows beat 0 after that edge. Further beats follow one per cycle with valid high, for 4 or 8 cycles in all.
- R7: Last is high only together with the final beat. Valid goes low on the following cycle unless a new burst was accepted on that final beat.
- R8: A start presented while the final beat is shown is accepted, and its beat 0 follows with no idle cycle.
- R9: In a length-4 burst, a start presented on any beat other than the final one is ignored: the address sequence continues unchanged and the error output is high for exactly the next cycle.
- R10: In a length-8 burst, a start presented while beat index 3 is shown is accepted. The old burst is cut and the new beat 0 follows. A start on any other non-final beat is ignored, and the error output pulses as in R9.
- R11: Length and ordering are captured with the start. Changing len8 or interleave during a burst has no effect on the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start request, one cycle |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being shown |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous-cycle start was illegal and dropped |

## Verification
The bench builds the block with COL_W = 12. This gives nine pass-through bits above the ordering field, so random upper values can show that no carry from the low-bit count leaks upward. Random starts, lengths and orderings are mixed with directed starts at every beat position, which puts both legal interruption points and every illegal one within reach.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
    localparam int BEAT_W = 3;

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic              len8;
        logic              ilv;
        logic              err;
    } seq_state_t;
endpackage

// File: rtl/burst_col_seq_order.sv
module burst_col_seq_order
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              len8_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  col_o
);
    logic [1:0] seq_low;
    logic       seq_b2;
    logic [2:0] ilv_low;
    logic [2:0] low;

    always_comb begin
        seq_low = base_i[1:0] + beat_i[1:0];
        // nibble select toggles only for the second half of an 8-beat burst
        seq_b2  = base_i[2] ^ (len8_i & beat_i[2]);
        ilv_low = base_i[2:0] ^ beat_i;
        low     = ilv_i ? ilv_low : {seq_b2, seq_low};
    end

    generate
        if (COL_W > BEAT_W) begin : g_upper
            assign col_o = {base_i[COL_W-1:BEAT_W], low};
        end else begin : g_narrow
            assign col_o = low[COL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_col_seq_gate.sv
module burst_col_seq_gate
    import burst_col_seq_pkg::*;
(
    input  logic              start_i,
    input  logic              active_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              len8_i,
    output logic              final_o,
    output logic              accept_o,
    output logic              illegal_o
);
    localparam logic [BEAT_W-1:0] LAST4 = 3'd3;
    localparam logic [BEAT_W-1:0] LAST8 = 3'd7;
    localparam logic [BEAT_W-1:0] HALF8 = 3'd3;

    logic cut_ok;

    always_comb begin
        final_o   = active_i && (beat_i == (len8_i ? LAST8 : LAST4));
        cut_ok    = active_i && len8_i && (beat_i == HALF8);
        accept_o  = start_i && (!active_i || final_o || cut_ok);
        illegal_o = start_i && !accept_o;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             len8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    seq_state_t       st_d, st_q;
    logic [COL_W-1:0] base_d, base_q;
    logic             final_beat;
    logic             accept;
    logic             illegal;

    burst_col_seq_gate u_gate (
        .start_i  (start_i),
        .active_i (st_q.active),
        .beat_i   (st_q.beat),
        .len8_i   (st_q.len8),
        .final_o  (final_beat),
        .accept_o (accept),
        .illegal_o(illegal)
    );

    burst_col_seq_order #(.COL_W(COL_W)) u_order (
        .base_i(base_q),
        .beat_i(st_q.beat),
        .len8_i(st_q.len8),
        .ilv_i (st_q.ilv),
        .col_o (col_o)
    );

    always_comb begin
        st_d     = st_q;
        base_d   = base_q;
        st_d.err = illegal;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.len8   = len8_i;
            st_d.ilv    = ilv_i;
            base_d      = col_i;
        end else if (st_q.active) begin
            if (final_beat) begin
                st_d.active = 1'b0;
                st_d.beat   = '0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            base_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = final_beat;
    assign err_o   = st_q.err;

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R6
    beats_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !accept) |=> $stable(col_o[COL_W-1:BEAT_W]));

    // R9
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && valid_o && !last_o && !accept) |=> err_o);

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(start_i && valid_o)) |=> !err_o);
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    localparam int COL_W = 12;
    localparam time HALF = 4ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic             len8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int q[$];
    bit cur_v = 0, cur_last = 0, cur_len8 = 0, err_exp = 0;
    int cur_addr = 0, cur_idx = 0;

    always #(HALF) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .len8_i(len8_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .err_o(err_o)
    );

    function automatic int beat_addr(int s, int i, bit il);
        int low;
        if (il) low = (s & 7) ^ i;
        else    low = ((s + i) & 3) | ((s & 4) ^ (i & 4));
        return (s & ~7) | low;
    endfunction

    task automatic compare(string tag);
        bit ok;
        ok = (valid_o == cur_v) && (last_o == (cur_v && cur_last)) && (err_o == err_exp)
             && (!cur_v || (int'(col_o) == cur_addr));
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s t=%0t actual v=%0b l=%0b e=%0b col=%0h expected v=%0b l=%0b e=%0b col=%0h",
                     tag, $time, valid_o, last_o, err_o, col_o,
                     cur_v, cur_v && cur_last, err_exp, cur_addr);
        end
    endtask

    // one cycle: check what is shown, drive inputs, advance the model
    task automatic cyc(bit st, int col, bit l8, bit il, string tag);
        bit legal;
        int n, e;
        @(negedge clk);
        compare(tag);
        start_i = st; col_i = col[COL_W-1:0]; len8_i = l8; ilv_i = il;
        legal = !cur_v || cur_last || (cur_len8 && cur_idx == 3);
        err_exp = 0;
        if (st) begin
            if (legal) begin
                q.delete();
                n = l8 ? 8 : 4;
                for (int i = 0; i < n; i++)
                    q.push_back((beat_addr(col & ((1 << COL_W) - 1), i, il) & 'hFFFF)
                                | ((i == n - 1) << 16) | (int'(l8) << 17) | (i << 18));
            end else begin
                err_exp = 1;
            end
        end
        if (q.size() > 0) begin
            e = q.pop_front();
            cur_v = 1; cur_addr = e & 'hFFFF; cur_last = e[16];
            cur_len8 = e[17]; cur_idx = (e >> 18) & 7;
        end else begin
            cur_v = 0; cur_last = 0; cur_idx = 0;
        end
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            compare("R1 in reset");
        end
        rst_n = 1'b1;
        idle(2, "R1 after reset");

        cyc(1, 'h2A8 | 2, 0, 0, "R2 seq4 start");  idle(6, "R2 seq4 from 2");
        cyc(1, 'h5F4 | 3, 0, 1, "R4 ilv4 start");  idle(6, "R4 ilv4 from 3");
        cyc(1, 'h100 | 1, 1, 0, "R3 seq8 start");  idle(10, "R3 seq8 from 1");
        cyc(1, 'hE08 | 5, 1, 0, "R3 seq8 start5"); idle(10, "R3 seq8 from 5");
        cyc(1, 'h3C0 | 3, 1, 1, "R4 ilv8 start");  idle(10, "R4 ilv8 from 3");
        cyc(1, 'hFF8 | 6, 0, 0, "R5 upper start"); idle(6, "R5 upper pass");

        // R8 seamless: second start on final beat
        cyc(1, 'h010, 0, 0, "R8 first");
        idle(3, "R8 beats");
        cyc(1, 'h023, 0, 1, "R8 seamless start");
        idle(6, "R8 follow-on");

        // R9 illegal start inside length-4
        cyc(1, 'h040, 0, 0, "R9 start");
        idle(1, "R9 beat");
        cyc(1, 'h077, 1, 1, "R9 mid start");
        idle(6, "R9 ignored");

        // R10 legal cut at beat 3 and illegal start at beat 5
        cyc(1, 'h080, 1, 0, "R10 start");
        idle(3, "R10 beats");
        cyc(1, 'h095, 1, 1, "R10 cut at half");
        idle(5, "R10 new burst");
        cyc(1, 'h0A2, 0, 0, "R10 illegal at beat5");
        idle(6, "R10 ignored");

        // R11 mode inputs toggled during burst
        cyc(1, 'h0C1, 1, 0, "R11 start");
        for (int k = 0; k < 7; k++) cyc(0, 'h0FF, k[0], ~k[0], "R11 held mode");
        idle(3, "R11 end");

        // R6 mixed random traffic
        for (int k = 0; k < 600; k++)
            cyc(($urandom % 4) == 0, int'($urandom % 4096), $urandom % 2, $urandom % 2, "R6 random");
        idle(10, "R7 drain");
        finish_run();
    end
endmodule